// File: doc/BRIEF.md
# Monitor Channel Byte Handshake Controller

This block carries single bytes across the monitor channel of a time-multiplexed serial frame of the GCI/IOM kind. Every byte is flow controlled by two per-frame control bits: E, which the sender raises while a byte is on offer, and A, which the receiver raises to acknowledge it. Serialisation and slot timing sit outside the block. Once per frame a single-cycle `frame_stb` marks the point where the block samples the incoming monitor byte and control bits and updates the outgoing ones. In this project a control bit that is "asserted" reads 1 on the port.

The host writes transmit bytes through a valid/ready pair and gets received bytes back as a one-cycle strobe, with a sticky interrupt flag that it can mask. Three command pulses control the protocol. Abort makes the receive side signal an abort request on A. Timeout breaks a deadlock caused by bad control-bit states on the line. Init clears all protocol state at once, so the channel can be switched to another use cleanly.

Top module: `gci_mon_ctrl`

## Requirements
- R1: A transmit byte is taken only in a `frame_stb` cycle, and only when the transmitter is idle or the current byte is being acknowledged in that frame (`a_in`=1 now, `a_in`=0 at the previous strobe). `tx_ready` is never high outside a strobe cycle, and it is low in any strobe cycle where a timeout is being applied.
- R2: After a byte is taken, `e_out`=1 and `mon_out` carries that byte. The same byte repeats on every frame until an acknowledge arrives.
- R3: When an acknowledge arrives and no new byte is taken, the transmitter returns to idle: `e_out`=0 and `mon_out`=8'hFF.
- R4: If `a_in` is 1 at two consecutive strobes while the transmitter holds a byte, that byte is dropped and `e_out` goes to 0. `tx_aborted` pulses for one cycle.
- R5: When the receiver sees the same byte with `e_in`=1 at two consecutive strobes, it delivers that byte on `rx_data` with a one-cycle `rx_valid` and drives `a_out`=1 for that one frame. It then clears its candidate, so the next byte again needs two fresh frames.
- R6: A strobe with `e_in`=0 clears the receive candidate. Two consecutive such strobes after any frame with `e_in`=1 pulse `rx_eom` once. Any further idle frames produce nothing.
- R7: `rx_irq` is set when a byte is delivered while `rx_irq_en`=1, stays set, and is cleared by `irq_ack`. A byte delivered while `rx_irq_en`=0 leaves it at 0.
- R8: After `cmd_abort`, `a_out` is 1 for the next two frames. No byte is delivered during those frames and the receive candidate is cleared.
- R9: After `cmd_timeout`, the next strobe sends the transmitter to idle and clears the receive candidate, and the data sampled in that frame is ignored.
- R10: `cmd_init` clears all state on the next clock edge, without waiting for a strobe.
- R11: Apart from init, `e_out`, `a_out` and `mon_out` change only on a clock edge where `frame_stb` was high.
- R12: After reset, `e_out`=0, `a_out`=0, `mon_out`=8'hFF, and `rx_irq`, `rx_valid`, `rx_eom` and `tx_aborted` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per frame; the sampling and update point |
| tx_data | input | 8 | Transmit byte from host |
| tx_valid | input | 1 | Host offers tx_data |
| tx_ready | output | 1 | Byte taken in this cycle when tx_valid is high |
| tx_aborted | output | 1 | Pulse: far end aborted the current byte |
| rx_data | output | 8 | Last delivered receive byte |
| rx_valid | output | 1 | Pulse: rx_data holds a new byte |
| rx_eom | output | 1 | Pulse: end of message detected |
| rx_irq_en | input | 1 | Interrupt mask, 1 enables |
| irq_ack | input | 1 | Clears rx_irq |
| rx_irq | output | 1 | Sticky receive interrupt |
| cmd_abort | input | 1 | Request an abort on A |
| cmd_timeout | input | 1 | Force recovery from a deadlock |
| cmd_init | input | 1 | Clear all protocol state |
| mon_in | input | 8 | Monitor byte received in this frame |
| e_in | input | 1 | Far-end E bit |
| a_in | input | 1 | Far-end A bit |
| mon_out | output | 8 | Monitor byte to send |
| e_out | output | 1 | Local E bit |
| a_out | output | 1 | Local A bit |

## Verification
A corrupted receive candidate shows up at the ports one frame later. Either `a_out` rises a frame early, on a byte seen only once, or it never rises on a byte that was repeated. `rx_valid` moves with it in the same cycle. A stuck transmit state appears on `e_out` and `mon_out` at the next strobe: the byte is not repeated, or it is not released after an acknowledge. A wrong abort or end-of-message count is visible within two frames as an `a_out` pulse or an `rx_eom` pulse of the wrong length or at the wrong time.

// File: rtl/gci_mon_ctrl.sv
module gci_mon_ctrl #(
  parameter int DW = 8,
  parameter logic [DW-1:0] IDLE_BYTE = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tx_aborted,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_eom,
  input  logic          rx_irq_en,
  input  logic          irq_ack,
  output logic          rx_irq,
  input  logic          cmd_abort,
  input  logic          cmd_timeout,
  input  logic          cmd_init,
  input  logic [DW-1:0] mon_in,
  input  logic          e_in,
  input  logic          a_in,
  output logic [DW-1:0] mon_out,
  output logic          e_out,
  output logic          a_out
);

  logic          tx_busy, a_prev, pend_ab, pend_to;
  logic [DW-1:0] tx_hold, cand, rx_q;
  logic          cand_v, a_q, active, idle1;
  logic          ab_left;
  logic          rx_v_q, eom_q, irq_q, txab_q;

  wire do_to     = cmd_timeout | pend_to;
  wire do_ab     = cmd_abort | pend_ab;
  wire ack_in    = tx_busy & a_in & ~a_prev;
  wire far_abort = tx_busy & a_in & a_prev;

  assign tx_ready   = frame_stb & ~do_to & (~tx_busy | ack_in);
  wire   take       = tx_ready & tx_valid;

  assign mon_out    = tx_hold;
  assign e_out      = tx_busy;
  assign a_out      = a_q;
  assign rx_data    = rx_q;
  assign rx_valid   = rx_v_q;
  assign rx_eom     = eom_q;
  assign rx_irq     = irq_q;
  assign tx_aborted = txab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_hold <= IDLE_BYTE; a_prev <= 1'b0;
      pend_ab <= 1'b0; pend_to <= 1'b0;
      cand <= '0; cand_v <= 1'b0; a_q <= 1'b0; ab_left <= 1'b0;
      active <= 1'b0; idle1 <= 1'b0; rx_q <= '0;
      rx_v_q <= 1'b0; eom_q <= 1'b0; irq_q <= 1'b0; txab_q <= 1'b0;
    end else if (cmd_init) begin
      tx_busy <= 1'b0; tx_hold <= IDLE_BYTE; a_prev <= 1'b0;
      pend_ab <= 1'b0; pend_to <= 1'b0;
      cand <= '0; cand_v <= 1'b0; a_q <= 1'b0; ab_left <= 1'b0;
      active <= 1'b0; idle1 <= 1'b0; rx_q <= '0;
      rx_v_q <= 1'b0; eom_q <= 1'b0; irq_q <= 1'b0; txab_q <= 1'b0;
    end else begin
      rx_v_q <= 1'b0;
      eom_q  <= 1'b0;
      txab_q <= 1'b0;
      if (irq_ack)     irq_q   <= 1'b0;
      if (cmd_abort)   pend_ab <= 1'b1;
      if (cmd_timeout) pend_to <= 1'b1;
      if (frame_stb) begin
        pend_ab <= 1'b0;
        pend_to <= 1'b0;
        a_prev  <= a_in;

        if (do_to) begin
          tx_busy <= 1'b0; tx_hold <= IDLE_BYTE;
        end else if (take) begin
          tx_busy <= 1'b1; tx_hold <= tx_data;
        end else if (far_abort) begin
          tx_busy <= 1'b0; tx_hold <= IDLE_BYTE; txab_q <= 1'b1;
        end else if (ack_in) begin
          tx_busy <= 1'b0; tx_hold <= IDLE_BYTE;
        end

        if (do_to) begin
          cand_v <= 1'b0; a_q <= 1'b0; ab_left <= 1'b0;
          active <= 1'b0; idle1 <= 1'b0;
        end else if (do_ab) begin
          cand_v <= 1'b0; a_q <= 1'b1; ab_left <= 1'b1;
          active <= 1'b0; idle1 <= 1'b0;
        end else if (ab_left) begin
          a_q <= 1'b1; ab_left <= 1'b0;
        end else if (e_in) begin
          active <= 1'b1;
          idle1  <= 1'b0;
          if (cand_v && mon_in == cand) begin
            rx_q   <= mon_in;
            rx_v_q <= 1'b1;
            a_q    <= 1'b1;
            cand_v <= 1'b0;
            if (rx_irq_en) irq_q <= 1'b1;
          end else begin
            cand   <= mon_in;
            cand_v <= 1'b1;
            a_q    <= 1'b0;
          end
        end else begin
          cand_v <= 1'b0;
          a_q    <= 1'b0;
          if (active) begin
            if (idle1) begin
              eom_q <= 1'b1; active <= 1'b0; idle1 <= 1'b0;
            end else begin
              idle1 <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

module gci_mon_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic          cmd_init,
  input logic          cmd_timeout,
  input logic          pend_to,
  input logic          tx_ready,
  input logic          tx_aborted,
  input logic          rx_valid,
  input logic          rx_eom,
  input logic          rx_irq,
  input logic          a_in,
  input logic [DW-1:0] mon_out,
  input logic          e_out,
  input logic          a_out
);

  // R1
  ready_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> frame_stb);

  // R2
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_out && frame_stb && !a_in && !cmd_timeout && !pend_to && !cmd_init)
      |=> (e_out && $stable(mon_out)));

  // R4
  abort_idles_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_aborted |-> !e_out);

  // R5
  deliver_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> a_out);

  // R6
  eom_not_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eom |-> !rx_valid);

  // R10
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_init |=> (!e_out && !a_out && !rx_irq));

  // R11
  frame_outputs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !cmd_init) |=> ($stable(e_out) && $stable(a_out) && $stable(mon_out)));

endmodule

bind gci_mon_ctrl gci_mon_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .cmd_init(cmd_init),
  .cmd_timeout(cmd_timeout), .pend_to(pend_to), .tx_ready(tx_ready),
  .tx_aborted(tx_aborted), .rx_valid(rx_valid), .rx_eom(rx_eom),
  .rx_irq(rx_irq), .a_in(a_in), .mon_out(mon_out), .e_out(e_out), .a_out(a_out)
);

// File: tb/gci_mon_ctrl_tb.sv
module gci_mon_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, frame_stb = 0;
  logic [7:0] tx_data = 0, mon_in = 0, rx_data, mon_out;
  logic tx_valid = 0, tx_ready, tx_aborted, rx_valid, rx_eom, rx_irq_en = 1, irq_ack = 0, rx_irq;
  logic cmd_abort = 0, cmd_timeout = 0, cmd_init = 0, e_in = 0, a_in = 0, e_out, a_out;
  logic rdy_s;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  gci_mon_ctrl u_dut (.*);

  // {e_in, mon_in, exp a_out, exp rx_valid, exp rx_eom}
  localparam logic [11:0] RXV [13] = '{
    {1'b1, 8'h3C, 3'b000}, {1'b1, 8'h3C, 3'b110}, {1'b1, 8'h3C, 3'b000},
    {1'b1, 8'h5A, 3'b000}, {1'b1, 8'h5A, 3'b110}, {1'b1, 8'hA5, 3'b000},
    {1'b0, 8'hA5, 3'b000}, {1'b1, 8'hA5, 3'b000}, {1'b0, 8'h00, 3'b000},
    {1'b0, 8'h00, 3'b001}, {1'b0, 8'h00, 3'b000}, {1'b1, 8'h77, 3'b000},
    {1'b1, 8'h77, 3'b110}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(logic e, logic [7:0] d, logic a);
    @(negedge clk);
    e_in = e; mon_in = d; a_in = a; frame_stb = 1;
    #1 rdy_s = tx_ready;
    @(negedge clk);
    frame_stb = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P*3); rst_n = 1;
    @(negedge clk);
    chk("R12 e_out", e_out, 0); chk("R12 a_out", a_out, 0);
    chk("R12 mon_out", mon_out, 8'hFF); chk("R12 irq", rx_irq, 0);
    chk("R12 pulses", {rx_valid, rx_eom, tx_aborted}, 0);
    chk("R1 ready off strobe", tx_ready, 0);

    for (int i = 0; i < 13; i++) begin
      frame(RXV[i][11], RXV[i][10:3], 1'b0);
      chk($sformatf("R5/R6 row%0d a_out", i), a_out, RXV[i][2]);
      chk($sformatf("R5 row%0d rx_valid", i), rx_valid, RXV[i][1]);
      chk($sformatf("R6 row%0d rx_eom", i), rx_eom, RXV[i][0]);
      if (RXV[i][1]) chk($sformatf("R5 row%0d rx_data", i), rx_data, RXV[i][10:3]);
    end

    chk("R7 irq set", rx_irq, 1);
    pulse(irq_ack);
    chk("R7 irq cleared", rx_irq, 0);
    rx_irq_en = 0;
    frame(1, 8'h12, 0); frame(1, 8'h12, 0);
    chk("R7 masked delivery", rx_valid, 1);
    chk("R7 masked irq", rx_irq, 0);
    rx_irq_en = 1;
    frame(0, 0, 0); frame(0, 0, 0); frame(0, 0, 0);

    // transmit path
    tx_data = 8'h81; tx_valid = 1;
    frame(0, 0, 0); tx_valid = 0;
    chk("R1 ready in idle strobe", rdy_s, 1);
    chk("R2 e_out", e_out, 1); chk("R2 byte", mon_out, 8'h81);
    tx_data = 8'h42; tx_valid = 1;
    frame(0, 0, 0);
    chk("R1 no ready while waiting", rdy_s, 0);
    chk("R2 repeat", mon_out, 8'h81);
    frame(0, 0, 1); tx_valid = 0;
    chk("R1 ready on ack", rdy_s, 1);
    chk("R2 next byte", mon_out, 8'h42); chk("R2 e next", e_out, 1);
    frame(0, 0, 0);
    chk("R2 repeat2", mon_out, 8'h42);
    frame(0, 0, 1);
    chk("R3 idle e", e_out, 0); chk("R3 idle byte", mon_out, 8'hFF);

    // far-end abort
    tx_data = 8'h99; tx_valid = 1; frame(0, 0, 0);
    tx_data = 8'h11; frame(0, 0, 1); tx_valid = 0;
    chk("R4 pre mon", mon_out, 8'h11);
    frame(0, 0, 1);
    chk("R4 aborted pulse", tx_aborted, 1);
    chk("R4 e dropped", e_out, 0);
    @(negedge clk);
    chk("R4 pulse one cycle", tx_aborted, 0);
    frame(0, 0, 0);

    // abort command
    pulse(cmd_abort);
    repeat (3) @(negedge clk);
    chk("R11 a_out steady before strobe", a_out, 0);
    frame(1, 8'h10, 0);
    chk("R8 a frame1", a_out, 1); chk("R8 no data1", rx_valid, 0);
    frame(1, 8'h10, 0);
    chk("R8 a frame2", a_out, 1); chk("R8 no data2", rx_valid, 0);
    frame(1, 8'h10, 0);
    chk("R8 a released", a_out, 0);
    frame(1, 8'h10, 0);
    chk("R8 resume ack", a_out, 1); chk("R8 resume data", rx_valid, 1);
    frame(0, 0, 0); frame(0, 0, 0);

    // timeout
    tx_data = 8'h33; tx_valid = 1; frame(0, 0, 0); tx_valid = 0;
    frame(1, 8'h44, 0);
    pulse(cmd_timeout);
    chk("R11 e_out steady", e_out, 1);
    tx_data = 8'h55; tx_valid = 1;
    frame(1, 8'h44, 0); tx_valid = 0;
    chk("R9 no ready", rdy_s, 0);
    chk("R9 tx idle", e_out, 0);
    chk("R9 no ack", a_out, 0); chk("R9 no data", rx_valid, 0);
    frame(1, 8'h44, 0);
    chk("R9 candidate restarted", a_out, 0);
    frame(1, 8'h44, 0);
    chk("R9 then ack", a_out, 1);

    // init
    tx_data = 8'h66; tx_valid = 1; frame(1, 8'h44, 0); tx_valid = 0;
    chk("R10 pre e", e_out, 1);
    pulse(cmd_init);
    chk("R10 e cleared", e_out, 0);
    chk("R10 byte idle", mon_out, 8'hFF);
    chk("R10 irq cleared", rx_irq, 0);
    chk("R10 a cleared", a_out, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule